// File: doc/BRIEF.md
# Serial Controller Interrupt Status Set

This block collects the interrupt events of a serial controller (transmit done, receive ready and receive overflow) and presents them as three registers' worth of state: a raw status register that latches each event, a masked status register that captures those raw bits whose enable is on, and a single level interrupt line. Software clears raw bits by writing ones to a write-to-clear strobe. The address decoding is done outside the block, and the block receives one strobe for each register that can be written.

The per-source enable bits do not sit next to each other in the controller's control word. They are taken from bits 5, 4 and 6 and remapped onto status bits 0, 1 and 2. The masked register accumulates: once a bit is captured it stays set until reset, even if the raw bit is cleared or the enable drops. Every size is a parameter. Each enable position is also a parameter, so the same block can serve a controller with a different control-word layout.

Top module: `irq_status_set`

## Requirements
- R1: While synchronous reset is high and on the first cycle after it, raw_stat, mask_stat and irq are all zero; reset also clears a previously captured masked state.
- R2: A 1 on evt_pulse bit n sets raw_stat bit n at the clock edge where it is sampled (bit 0 transmit done, bit 1 receive ready, bit 2 receive overflow).
- R3: With clr_wr high, a 1 in wr_data bit n (n < 3) clears raw_stat bit n at that edge; zero bits and wr_data bits 3 and above have no effect, and wr_data has no effect while clr_wr is low.
- R4: When an event and a clear hit the same raw bit in the same cycle, the bit ends up set.
- R5: The enable for status bit 0 is ctrl_word bit 5, for status bit 1 ctrl_word bit 4, and for status bit 2 ctrl_word bit 6; no other ctrl_word bit affects the block.
- R6: mask_stat bit n becomes 1 at the edge after a cycle in which raw_stat bit n and its enable were both 1, and it never becomes 1 otherwise.
- R7: A set mask_stat bit stays set when its raw bit is cleared or its enable drops; only reset clears it.
- R8: irq is 1 exactly when mask_stat is nonzero, in the same cycle.
- R9: Strobes raw_wr and mask_wr, with any wr_data, change neither raw_stat nor mask_stat.
- R10: Without an event or a clear, raw_stat keeps its value.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| evt_pulse | input | NUM_SRC (3) | One-cycle event pulses: bit 0 transmit done, bit 1 receive ready, bit 2 receive overflow |
| ctrl_word | input | CTRL_W (32) | Controller control word that carries the scattered enable bits |
| clr_wr | input | 1 | Write strobe to the clear register |
| raw_wr | input | 1 | Write strobe aimed at the raw status register (ignored) |
| mask_wr | input | 1 | Write strobe aimed at the masked status register (ignored) |
| wr_data | input | DATA_W (32) | Bus write data |
| raw_stat | output | NUM_SRC (3) | Raw status register |
| mask_stat | output | NUM_SRC (3) | Accumulated masked status register |
| irq | output | 1 | Level interrupt, OR of mask_stat |

## Verification
The assertions check on every cycle that raw bits are set by events, cleared by clear writes unless an event arrives at the same time, and otherwise held. They also check that masked bits only appear after an enabled raw bit, that they never drop, and that irq follows the masked register. The enable mapping from the control word, the immunity of the state to writes aimed at the read-only registers, the ignored upper clear bits and the clearing of captured state by reset depend on the values driven at the ports. Only the bench's vector table and its directed scenarios exercise those.

// File: rtl/irq_pkg.sv
package irq_pkg;
  localparam int unsigned SRC_COUNT = 3;
  localparam int unsigned SRC_TX_DONE = 0;
  localparam int unsigned SRC_RX_READY = 1;
  localparam int unsigned SRC_RX_OVF = 2;
  // enable position in the control word, per status bit
  localparam int unsigned EN_POS_DEF [SRC_COUNT] = '{5, 4, 6};
endpackage

// File: rtl/irq_en_remap.sv
module irq_en_remap #(
  parameter int unsigned NUM_SRC = irq_pkg::SRC_COUNT,
  parameter int unsigned CTRL_W  = 32,
  parameter int unsigned EN_POS [NUM_SRC] = irq_pkg::EN_POS_DEF
) (
  input  logic [CTRL_W-1:0]  ctrl_word,
  output logic [NUM_SRC-1:0] en_vec
);
  for (genvar i = 0; i < NUM_SRC; i++) begin : g_map
    assign en_vec[i] = ctrl_word[EN_POS[i]];
  end

  logic unused_ctrl;
  assign unused_ctrl = ^ctrl_word;
endmodule

// File: rtl/irq_raw_reg.sv
module irq_raw_reg #(
  parameter int unsigned NUM_SRC = irq_pkg::SRC_COUNT
) (
  input  logic               clk,
  input  logic               rst,
  input  logic [NUM_SRC-1:0] set_vec,
  input  logic [NUM_SRC-1:0] clr_vec,
  output logic [NUM_SRC-1:0] raw_q
);
  always_ff @(posedge clk) begin
    if (rst) raw_q <= '0;
    else     raw_q <= (raw_q & ~clr_vec) | set_vec;
  end

  AST_RAW_SET: assert property (@(posedge clk) disable iff (rst)
    (|set_vec) |=> ((raw_q & $past(set_vec)) == $past(set_vec))); // R2
  AST_SET_WINS: assert property (@(posedge clk) disable iff (rst)
    (|(set_vec & clr_vec)) |=> ((raw_q & $past(set_vec & clr_vec)) == $past(set_vec & clr_vec))); // R4
  AST_RAW_CLR: assert property (@(posedge clk) disable iff (rst)
    (|(clr_vec & ~set_vec)) |=> ((raw_q & $past(clr_vec & ~set_vec)) == '0)); // R3
  AST_RAW_HOLD: assert property (@(posedge clk) disable iff (rst)
    ((set_vec == '0) && (clr_vec == '0)) |=> $stable(raw_q)); // R10
endmodule

// File: rtl/irq_mask_acc.sv
module irq_mask_acc #(
  parameter int unsigned NUM_SRC = irq_pkg::SRC_COUNT
) (
  input  logic               clk,
  input  logic               rst,
  input  logic [NUM_SRC-1:0] raw_in,
  input  logic [NUM_SRC-1:0] en_in,
  output logic [NUM_SRC-1:0] mask_q,
  output logic               irq_q
);
  logic [NUM_SRC-1:0] mask_nxt;
  assign mask_nxt = mask_q | (raw_in & en_in);

  always_ff @(posedge clk) begin
    if (rst) begin
      mask_q <= '0;
      irq_q  <= 1'b0;
    end else begin
      mask_q <= mask_nxt;
      irq_q  <= |mask_nxt;
    end
  end

  AST_MASK_CAPTURE: assert property (@(posedge clk) disable iff (rst)
    (|(raw_in & en_in)) |=> ((mask_q & $past(raw_in & en_in)) == $past(raw_in & en_in))); // R6
  AST_MASK_ONLY_ENABLED: assert property (@(posedge clk) disable iff (rst)
    1'b1 |=> ((mask_q & ~$past(mask_q) & ~$past(raw_in & en_in)) == '0)); // R6
  AST_MASK_STICKY: assert property (@(posedge clk) disable iff (rst)
    1'b1 |=> ((mask_q & $past(mask_q)) == $past(mask_q))); // R7
  AST_IRQ_LEVEL: assert property (@(posedge clk) disable iff (rst)
    irq_q == (mask_q != '0)); // R8
endmodule

// File: rtl/irq_status_set.sv
module irq_status_set #(
  parameter int unsigned NUM_SRC = irq_pkg::SRC_COUNT,
  parameter int unsigned CTRL_W  = 32,
  parameter int unsigned DATA_W  = 32,
  parameter int unsigned EN_POS [NUM_SRC] = irq_pkg::EN_POS_DEF
) (
  input  logic               clk,
  input  logic               rst,
  input  logic [NUM_SRC-1:0] evt_pulse,
  input  logic [CTRL_W-1:0]  ctrl_word,
  input  logic               clr_wr,
  input  logic               raw_wr,
  input  logic               mask_wr,
  input  logic [DATA_W-1:0]  wr_data,
  output logic [NUM_SRC-1:0] raw_stat,
  output logic [NUM_SRC-1:0] mask_stat,
  output logic               irq
);
  logic [NUM_SRC-1:0] en_vec;
  logic [NUM_SRC-1:0] clr_vec;

  // clear decode: only the low status positions of the clear write count
  assign clr_vec = clr_wr ? wr_data[NUM_SRC-1:0] : '0;

  // writes aimed at the status registers are read-only and dropped
  logic unused_ro;
  assign unused_ro = ^{raw_wr, mask_wr, wr_data[DATA_W-1:NUM_SRC]};

  irq_en_remap #(.NUM_SRC(NUM_SRC), .CTRL_W(CTRL_W), .EN_POS(EN_POS)) u_remap (
    .ctrl_word (ctrl_word),
    .en_vec    (en_vec)
  );

  irq_raw_reg #(.NUM_SRC(NUM_SRC)) u_raw (
    .clk     (clk),
    .rst     (rst),
    .set_vec (evt_pulse),
    .clr_vec (clr_vec),
    .raw_q   (raw_stat)
  );

  irq_mask_acc #(.NUM_SRC(NUM_SRC)) u_mask (
    .clk    (clk),
    .rst    (rst),
    .raw_in (raw_stat),
    .en_in  (en_vec),
    .mask_q (mask_stat),
    .irq_q  (irq)
  );

  AST_RO_WR_IGNORED: assert property (@(posedge clk) disable iff (rst)
    ((raw_wr || mask_wr) && !clr_wr && (evt_pulse == '0)) |=> $stable(raw_stat)); // R9
endmodule

// File: tb/tb_irq_status_set.sv
module tb_irq_status_set;
  localparam int CLK_PERIOD = 10;
  localparam int NS = 3;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic [NS-1:0] evt_pulse = '0;
  logic [31:0]   ctrl_word = '0;
  logic          clr_wr = 1'b0;
  logic          raw_wr = 1'b0;
  logic          mask_wr = 1'b0;
  logic [31:0]   wr_data = '0;
  logic [NS-1:0] raw_stat;
  logic [NS-1:0] mask_stat;
  logic          irq;

  int checks = 0;
  int errors = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  irq_status_set dut (
    .clk(clk), .rst(rst), .evt_pulse(evt_pulse), .ctrl_word(ctrl_word),
    .clr_wr(clr_wr), .raw_wr(raw_wr), .mask_wr(mask_wr), .wr_data(wr_data),
    .raw_stat(raw_stat), .mask_stat(mask_stat), .irq(irq)
  );

  typedef struct packed {
    logic [2:0] evt;
    logic       cw;
    logic [2:0] clr;
    logic [7:0] ctrl;
    logic [2:0] e_raw;
    logic [2:0] e_mask;
    logic       e_irq;
  } vec_t;

  // expected state after the one edge each row is applied for
  localparam int NV = 9;
  localparam vec_t TABLE [NV] = '{
    '{3'b001, 1'b0, 3'b000, 8'h00, 3'b001, 3'b000, 1'b0}, // R2 tx done, no enable
    '{3'b000, 1'b0, 3'b000, 8'h10, 3'b001, 3'b000, 1'b0}, // R5 rx enable does not catch tx
    '{3'b010, 1'b0, 3'b000, 8'h10, 3'b011, 3'b000, 1'b0}, // R2 R6 one-cycle lag
    '{3'b000, 1'b0, 3'b000, 8'h10, 3'b011, 3'b010, 1'b1}, // R6 R8 capture
    '{3'b000, 1'b1, 3'b010, 8'h00, 3'b001, 3'b010, 1'b1}, // R3 R7 sticky
    '{3'b000, 1'b0, 3'b000, 8'h20, 3'b001, 3'b011, 1'b1}, // R5 bit5 -> status0
    '{3'b100, 1'b1, 3'b100, 8'h8F, 3'b101, 3'b011, 1'b1}, // R4 R5 other bits idle
    '{3'b000, 1'b1, 3'b111, 8'h40, 3'b000, 3'b111, 1'b1}, // R3 R5 bit6 -> status2
    '{3'b000, 1'b0, 3'b000, 8'h00, 3'b000, 3'b111, 1'b1}  // R7 R10
  };

  task automatic chk(input string req, input logic [2:0] act, input logic [2:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %b expected %b", req, act, exp);
    end
  endtask

  task automatic chk_all(input string req, input logic [2:0] r, input logic [2:0] m, input logic i);
    chk({req, " raw"}, raw_stat, r);
    chk({req, " mask"}, mask_stat, m);
    chk({req, " irq"}, {2'b0, irq}, {2'b0, i});
  endtask

  // drive at a falling edge, hold for one rising edge, release
  task automatic step(input logic [2:0] e, input logic cw, input logic rw, input logic mw,
                      input logic [31:0] d, input logic [31:0] c);
    evt_pulse = e; clr_wr = cw; raw_wr = rw; mask_wr = mw; wr_data = d; ctrl_word = c;
    @(negedge clk);
    evt_pulse = '0; clr_wr = 1'b0; raw_wr = 1'b0; mask_wr = 1'b0; wr_data = '0;
  endtask

  initial begin
    #(CLK_PERIOD * 100000);
    checks++; errors++;
    $display("FAIL watchdog: actual timeout expected finish");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    chk_all("R1 in reset", 3'b000, 3'b000, 1'b0);
    rst = 1'b0;
    @(negedge clk);
    chk_all("R1 after reset", 3'b000, 3'b000, 1'b0);

    for (int k = 0; k < NV; k++) begin
      step(TABLE[k].evt, TABLE[k].cw, 1'b0, 1'b0, {29'b0, TABLE[k].clr}, {24'b0, TABLE[k].ctrl});
      chk_all($sformatf("row %0d", k), TABLE[k].e_raw, TABLE[k].e_mask, TABLE[k].e_irq);
    end

    // R1: reset wipes a captured masked state
    rst = 1'b1;
    @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    chk_all("R1 reset clears capture", 3'b000, 3'b000, 1'b0);

    // R9: writes aimed at read-only registers
    step(3'b000, 1'b0, 1'b1, 1'b1, 32'hFFFF_FFFF, 32'h0000_0070);
    chk_all("R9 ro write", 3'b000, 3'b000, 1'b0);

    // set all raw bits with enables off
    step(3'b111, 1'b0, 1'b0, 1'b0, 32'h0, 32'h0);
    chk("R2 all events", raw_stat, 3'b111);
    step(3'b000, 1'b0, 1'b1, 1'b1, 32'h0, 32'h0);
    chk("R9 ro write zeros", raw_stat, 3'b111);

    // R3: upper clear bits and data without strobe have no effect
    step(3'b000, 1'b1, 1'b0, 1'b0, 32'hFFFF_FFF8, 32'h0);
    chk("R3 upper clear bits", raw_stat, 3'b111);
    step(3'b000, 1'b0, 1'b0, 1'b0, 32'h7, 32'h0);
    chk("R3 data without strobe", raw_stat, 3'b111);

    // R10: hold over several idle cycles
    repeat (4) @(negedge clk);
    chk("R10 hold", raw_stat, 3'b111);

    // R5: every non-enable control bit set, nothing captured
    step(3'b000, 1'b0, 1'b0, 1'b0, 32'h0, 32'hFFFF_FF8F);
    @(negedge clk);
    chk("R5 stray ctrl bits", mask_stat, 3'b000);
    chk("R8 irq low", {2'b0, irq}, 3'b000);

    // R6: overflow enable; capture lands one edge after raw is seen
    step(3'b000, 1'b0, 1'b0, 1'b0, 32'h0, 32'h0000_0040);
    chk("R6 capture edge", mask_stat, 3'b100);
    chk("R8 irq high", {2'b0, irq}, 3'b001);

    // R7: clear raw and drop enables, mask holds
    step(3'b000, 1'b1, 1'b0, 1'b0, 32'h7, 32'h0);
    @(negedge clk);
    chk("R7 raw cleared", raw_stat, 3'b000);
    chk("R7 mask holds", mask_stat, 3'b100);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule